// File: doc/BRIEF.md
# Dual Reload Down-Counter Timer

This block provides two independent down-counting timers behind a small register interface driven by single-cycle read and write strobes. Each timer has its own count and reload registers. Both timers share one control register and one event-status register. A timer counts either pulses on a synchronous reference-tick input or an internal tick that is the main clock divided by a power of two. A single free-running prescaler counter serves both timers.

When a running timer sees a tick while its count is zero, it expires. In periodic mode the count then restarts from the reload register, so loading N-1 into both registers gives a period of N ticks. In one-shot mode the count stays at zero and the timer's run bit clears itself. Every expiry sets a sticky status bit, and that bit drives the timer's interrupt output directly. Software clears a status bit by writing zero to it. Loading all ones into both the count and the reload register gives a free-running counter whose inverted value counts upward.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset every register reads zero, both interrupt outputs are low and no timer runs.
- R2: Registers are at byte addresses 0x00 control, 0x04 status, 0x10 reload A, 0x14 count A, 0x18 reload B and 0x1C count B. A read strobe latches the addressed register onto the read-data output at the next edge, and unknown addresses read zero. Control keeps only bits 0-3, 11, 12 and 19-24. All other control bits read zero.
- R3: Control bit 11 (timer A) or bit 12 (timer B) selects the reference-tick input as the count source. When the bit is clear, the timer ticks once every 2^e main clocks, where e is the 3-bit field at bits 19-21 (A) or bits 22-24 (B). e=0 ticks every clock.
- R4: While running, the count decreases by one on each tick. A write to the count register loads it at any time. A write in the same cycle as a tick takes priority, and that tick is discarded.
- R5: When a running timer ticks with a count of zero and its auto-reload bit is set (bit 1 for A, bit 3 for B), it expires and the count becomes the reload register value.
- R6: When a running timer ticks with a count of zero and auto-reload is clear, it expires, the count stays at zero and its run bit (bit 0 for A, bit 2 for B) clears. A control write in the same cycle takes priority over this clearing.
- R7: Expiry sets status bit 0 (A) or bit 8 (B). A status write clears each of these bits whose written value is 0 and leaves a bit unchanged when 1 is written. An expiry in the same cycle as a clear leaves the bit set.
- R8: The interrupt outputs irq_a_o and irq_b_o each equal their timer's status bit.
- R9: While a timer's run bit is clear, its count holds, and the status bit is not changed by that timer.
- R10: The prescaler runs freely from reset whether or not any timer is enabled, and both timers share it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick_i | input | 1 | Single-cycle reference tick, synchronous to clk |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid the cycle after rd_en_i |
| irq_a_o | output | 1 | Timer A interrupt (status bit 0) |
| irq_b_o | output | 1 | Timer B interrupt (status bit 8) |

## Verification
The bench builds the block with its defaults: 32-bit counters and data and a 5-bit address. This lets an all-ones free-running count and every register offset be used as they stand. The prescaler exponents used are 0, 2, 3 and 5. Exponent 0 makes a timer with reload zero expire on every clock, which forces a status clear and an expiry into the same cycle. The larger exponents exercise the shared prescaler phase against both timers running at once. Reference-tick pulses drive one-shot and periodic expiry at exactly known points.

// File: rtl/dtmr_pkg.sv
// Shared constants for the dual reload timer: register offsets and
// control/status bit positions, computed per timer index.
package dtmr_pkg;
    localparam int NCH   = 2;   // number of timers
    localparam int EXP_W = 3;   // prescaler exponent field width

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h04;

    function automatic logic [7:0] ofs_reload(input int ch);
        return 8'(8'h10 + 8 * ch);
    endfunction

    function automatic logic [7:0] ofs_count(input int ch);
        return 8'(8'h14 + 8 * ch);
    endfunction

    function automatic int pos_run(input int ch);
        return 2 * ch;
    endfunction

    function automatic int pos_autold(input int ch);
        return 2 * ch + 1;
    endfunction

    function automatic int pos_refsel(input int ch);
        return 11 + ch;
    endfunction

    function automatic int pos_exp(input int ch);
        return 19 + EXP_W * ch;
    endfunction

    function automatic int pos_stat(input int ch);
        return 8 * ch;
    endfunction
endpackage

// File: rtl/dtmr_prescaler.sv
// Shared free-running prescaler. One counter runs from reset; each
// timer gets a tick whenever the low e bits of the counter are all
// ones, i.e. once every 2^e clocks. Assumes e never exceeds PW.
module dtmr_prescaler #(
    parameter int EXP_W = 3,
    parameter int NCH   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NCH-1:0][EXP_W-1:0]   exp_i,
    output logic [NCH-1:0]              tick_o
);
    localparam int PW = (1 << EXP_W) - 1;

    logic [PW-1:0] pcnt_q;

    function automatic logic [PW-1:0] low_mask(input logic [EXP_W-1:0] e);
        logic [PW-1:0] m;
        m = '0;
        for (int b = 0; b < PW; b++) begin
            m[b] = (b < int'(e));
        end
        return m;
    endfunction

    // Free-running counter, independent of any timer state.
    always_ff @(posedge clk) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_q + 1'b1;
    end

    // Per-timer tick decode from the shared counter.
    for (genvar g = 0; g < NCH; g++) begin : g_tick
        logic [PW-1:0] mask;
        always_comb begin
            mask      = low_mask(exp_i[g]);
            tick_o[g] = ((pcnt_q & mask) == mask);
        end
    end
endmodule

// File: rtl/dtmr_channel.sv
// One down-counting timer: count and reload registers plus expiry
// detection. A count write overrides the tick in the same cycle.
// Assumes tick_i is a single-cycle enable in the clk domain.
module dtmr_channel #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          run_i,
    input  logic          autold_i,
    input  logic          wr_val_i,
    input  logic          wr_rel_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] count_o,
    output logic [DW-1:0] reload_o,
    output logic          expire_o
);
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] rel_q;
    logic          step;

    assign step     = run_i & tick_i & ~wr_val_i;
    assign expire_o = step & (cnt_q == '0);
    assign count_o  = cnt_q;
    assign reload_o = rel_q;

    // Count register: software load, decrement, or reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_val_i) begin
            cnt_q <= wdata_i;
        end else if (step) begin
            if (cnt_q == '0) begin
                if (autold_i) cnt_q <= rel_q;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Reload register: written only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)        rel_q <= '0;
        else if (wr_rel_i) rel_q <= wdata_i;
    end
endmodule

// File: rtl/dtmr_ctrl.sv
// Shared control and status registers. Control keeps only the defined
// bits; one-shot expiry clears the run bit unless control is written
// the same cycle. Status bits are sticky, cleared by writing zero,
// and a coincident expiry wins over the clear.
module dtmr_ctrl #(
    parameter int DW    = 32,
    parameter int EXP_W = 3,
    parameter int NCH   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_ctrl_i,
    input  logic                        wr_stat_i,
    input  logic [DW-1:0]               wdata_i,
    input  logic [NCH-1:0]              expire_i,
    output logic [NCH-1:0]              run_o,
    output logic [NCH-1:0]              autold_o,
    output logic [NCH-1:0]              refsel_o,
    output logic [NCH-1:0][EXP_W-1:0]   exp_o,
    output logic [NCH-1:0]              status_o,
    output logic [DW-1:0]               ctrl_word_o,
    output logic [DW-1:0]               stat_word_o
);
    import dtmr_pkg::*;

    function automatic logic [DW-1:0] defined_bits();
        logic [DW-1:0] m;
        m = '0;
        for (int c = 0; c < NCH; c++) begin
            m[pos_run(c)]    = 1'b1;
            m[pos_autold(c)] = 1'b1;
            m[pos_refsel(c)] = 1'b1;
            for (int b = 0; b < EXP_W; b++) m[pos_exp(c) + b] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DW-1:0] CTRL_MASK = defined_bits();

    logic [DW-1:0]  ctrl_q;
    logic [DW-1:0]  stop_mask;
    logic [NCH-1:0] stat_q;
    logic [NCH-1:0] clr_req;

    // Run bits to drop because a one-shot timer expired.
    always_comb begin
        stop_mask = '0;
        for (int c = 0; c < NCH; c++) begin
            stop_mask[pos_run(c)] = expire_i[c] & ~ctrl_q[pos_autold(c)];
        end
    end

    // Control register: software write or one-shot self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctrl_q <= '0;
        else if (wr_ctrl_i) ctrl_q <= wdata_i & CTRL_MASK;
        else                ctrl_q <= ctrl_q & ~stop_mask;
    end

    // Which status bits software asks to clear this cycle.
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            clr_req[c] = wr_stat_i & ~wdata_i[pos_stat(c)];
        end
    end

    // Sticky status: expiry sets, write-zero clears, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= expire_i | (stat_q & ~clr_req);
    end

    // Field extraction and status word assembly.
    always_comb begin
        stat_word_o = '0;
        for (int c = 0; c < NCH; c++) begin
            run_o[c]    = ctrl_q[pos_run(c)];
            autold_o[c] = ctrl_q[pos_autold(c)];
            refsel_o[c] = ctrl_q[pos_refsel(c)];
            exp_o[c]    = ctrl_q[pos_exp(c) +: EXP_W];
            stat_word_o[pos_stat(c)] = stat_q[c];
        end
    end

    assign status_o    = stat_q;
    assign ctrl_word_o = ctrl_q;
endmodule

// File: rtl/dual_reload_timer.sv
// Top of the dual reload timer: address decode, count source select,
// two timer channels, shared prescaler and control/status, and a
// registered read port. Assumes ADDR_W >= 5 and DW >= 25.
module dual_reload_timer #(
    parameter int DW     = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic              irq_a_o,
    output logic              irq_b_o
);
    import dtmr_pkg::*;

    logic                      wr_ctrl, wr_stat;
    logic [NCH-1:0]            wr_val, wr_rel;
    logic [NCH-1:0]            run, autold, refsel, ptick, tick, expire, status;
    logic [NCH-1:0][EXP_W-1:0] expo;
    logic [NCH-1:0][DW-1:0]    count, reload;
    logic [DW-1:0]             ctrl_word, stat_word, rd_mux, rdata_q;

    // Write strobe decode for the shared registers.
    assign wr_ctrl = wr_en_i & (addr_i == ADDR_W'(OFS_CTRL));
    assign wr_stat = wr_en_i & (addr_i == ADDR_W'(OFS_STAT));

    dtmr_prescaler #(.EXP_W(EXP_W), .NCH(NCH)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .exp_i  (expo),
        .tick_o (ptick)
    );

    dtmr_ctrl #(.DW(DW), .EXP_W(EXP_W), .NCH(NCH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ctrl_i   (wr_ctrl),
        .wr_stat_i   (wr_stat),
        .wdata_i     (wdata_i),
        .expire_i    (expire),
        .run_o       (run),
        .autold_o    (autold),
        .refsel_o    (refsel),
        .exp_o       (expo),
        .status_o    (status),
        .ctrl_word_o (ctrl_word),
        .stat_word_o (stat_word)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Per-timer write decode and count source select.
        assign wr_val[g] = wr_en_i & (addr_i == ADDR_W'(ofs_count(g)));
        assign wr_rel[g] = wr_en_i & (addr_i == ADDR_W'(ofs_reload(g)));
        assign tick[g]   = refsel[g] ? ref_tick_i : ptick[g];

        dtmr_channel #(.DW(DW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick[g]),
            .run_i    (run[g]),
            .autold_i (autold[g]),
            .wr_val_i (wr_val[g]),
            .wr_rel_i (wr_rel[g]),
            .wdata_i  (wdata_i),
            .count_o  (count[g]),
            .reload_o (reload[g]),
            .expire_o (expire[g])
        );
    end

    // Read multiplexer over all registers; unknown offsets give zero.
    always_comb begin
        rd_mux = '0;
        if (addr_i == ADDR_W'(OFS_CTRL)) rd_mux = ctrl_word;
        if (addr_i == ADDR_W'(OFS_STAT)) rd_mux = stat_word;
        for (int c = 0; c < NCH; c++) begin
            if (addr_i == ADDR_W'(ofs_count(c)))  rd_mux = count[c];
            if (addr_i == ADDR_W'(ofs_reload(c))) rd_mux = reload[c];
        end
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_en_i) rdata_q <= rd_mux;
    end

    assign rdata_o = rdata_q;
    assign irq_a_o = status[0];
    assign irq_b_o = status[1];
endmodule

// File: rtl/dtmr_checker.sv
// Checker for the dual reload timer: counting, reload, one-shot stop,
// freeze and interrupt causality, per timer. Bound to the top below.
module dtmr_checker #(
    parameter int DW  = 32,
    parameter int NCH = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   irq_a_o,
    input logic                   irq_b_o,
    input logic                   wr_ctrl,
    input logic [NCH-1:0]         run,
    input logic [NCH-1:0]         autold,
    input logic [NCH-1:0]         tick,
    input logic [NCH-1:0]         expire,
    input logic [NCH-1:0]         wr_val,
    input logic [NCH-1:0][DW-1:0] count,
    input logic [NCH-1:0][DW-1:0] reload
);
    logic [NCH-1:0] irq;
    assign irq = {irq_b_o, irq_a_o};

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R4
        count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run[g] && tick[g] && !wr_val[g] && count[g] != '0)
            |=> count[g] == $past(count[g]) - DW'(1));

        // R5
        reload_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run[g] && tick[g] && !wr_val[g] && count[g] == '0 && autold[g])
            |=> count[g] == $past(reload[g]));

        // R6
        oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (expire[g] && !autold[g] && !wr_ctrl) |=> !run[g]);

        // R9
        frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[g] && !wr_val[g]) |=> $stable(count[g]));

        // R8
        irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq[g]) |-> $past(expire[g]));

        // R7
        expiry_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            expire[g] |=> irq[g]);
    end
endmodule

bind dual_reload_timer dtmr_checker #(.DW(DW), .NCH(dtmr_pkg::NCH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_a_o (irq_a_o),
    .irq_b_o (irq_b_o),
    .wr_ctrl (wr_ctrl),
    .run     (run),
    .autold  (autold),
    .tick    (tick),
    .expire  (expire),
    .wr_val  (wr_val),
    .count   (count),
    .reload  (reload)
);

// File: tb/dual_reload_timer_tb_top.sv
module dual_reload_timer_tb_top;
    localparam int DW = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_tick = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq_a, irq_b;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dual_reload_timer #(.DW(DW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_a_o(irq_a), .irq_b_o(irq_b)
    );

    task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_ctrl, m_stat, m_rdata;
    logic [31:0] m_cnt [2];
    logic [31:0] m_rel [2];
    int          m_pre;

    function automatic logic [31:0] m_read(input logic [AW-1:0] a);
        case (a)
            5'h00: return m_ctrl;
            5'h04: return m_stat;
            5'h10: return m_rel[0];
            5'h14: return m_cnt[0];
            5'h18: return m_rel[1];
            5'h1C: return m_cnt[1];
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_stat = 0; m_rdata = 0; m_pre = 0;
            for (int c = 0; c < 2; c++) begin m_cnt[c] = 0; m_rel[c] = 0; end
        end else begin
            logic [1:0]  fired, stop;
            logic [31:0] nctrl;
            if (rd_en) m_rdata = m_read(addr);
            fired = 0; stop = 0;
            for (int c = 0; c < 2; c++) begin
                int  e;
                bit  tk, on, ar;
                e  = int'(m_ctrl[19 + 3*c +: 3]);
                tk = m_ctrl[11 + c] ? ref_tick : ((m_pre % (1 << e)) == (1 << e) - 1);
                on = m_ctrl[2*c];
                ar = m_ctrl[2*c + 1];
                if (wr_en && addr == AW'(5'h14 + 8*c)) m_cnt[c] = wdata;
                else if (on && tk) begin
                    if (m_cnt[c] == 0) begin
                        fired[c] = 1;
                        if (ar) m_cnt[c] = m_rel[c];
                        else    stop[c] = 1;
                    end else m_cnt[c] = m_cnt[c] - 1;
                end
                if (wr_en && addr == AW'(5'h10 + 8*c)) m_rel[c] = wdata;
            end
            nctrl = m_ctrl;
            if (wr_en && addr == 5'h00) nctrl = wdata & 32'h01F8180F;
            else begin
                if (stop[0]) nctrl[0] = 0;
                if (stop[1]) nctrl[2] = 0;
            end
            m_ctrl = nctrl;
            if (wr_en && addr == 5'h04) begin
                if (!wdata[0]) m_stat[0] = 0;
                if (!wdata[8]) m_stat[8] = 0;
            end
            if (fired[0]) m_stat[0] = 1;
            if (fired[1]) m_stat[8] = 1;
            m_pre = (m_pre + 1) % 128;
        end
    end

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R8 irq_a", {31'b0, irq_a}, {31'b0, m_stat[0]});
            check("R8 irq_b", {31'b0, irq_b}, {31'b0, m_stat[8]});
            check("R2 rdata", rdata, m_rdata);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0; d = rdata;
    endtask

    task automatic pulse();
        @(negedge clk); ref_tick = 1;
        @(negedge clk); ref_tick = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] r, r2;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        rd(5'h00, r); check("R1 ctrl", r, 0);
        rd(5'h04, r); check("R1 status", r, 0);
        rd(5'h14, r); check("R1 count A", r, 0);
        check("R1 irq", {30'b0, irq_b, irq_a}, 0);

        // R2: only defined control bits kept, unknown address reads zero
        wr(5'h00, 32'hFFFF_FFF0);
        rd(5'h00, r); check("R2 ctrl mask", r, 32'h01F8_1800);
        wr(5'h00, 0);
        wr(5'h08, 32'h1234_5678);
        rd(5'h08, r); check("R2 unknown", r, 0);

        // R6: one-shot on timer B driven by reference ticks
        wr(5'h1C, 2);
        wr(5'h00, 32'h0000_1004);
        pulse(); pulse();
        check("R6 not yet", {31'b0, irq_b}, 0);
        pulse();
        check("R6 expired irq", {31'b0, irq_b}, 1);
        rd(5'h00, r); check("R6 run cleared", r, 32'h0000_1000);
        rd(5'h1C, r); check("R6 count stays 0", r, 0);

        // R7: write 1 keeps, write 0 clears
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h04, r); check("R7 write1 keeps", r, 32'h100);
        wr(5'h04, 0);
        rd(5'h04, r); check("R7 write0 clears", r, 0);

        // R5: periodic timer A with reference ticks, period 3
        wr(5'h10, 2); wr(5'h14, 2);
        wr(5'h00, 32'h0000_0803);
        pulse(); pulse(); pulse();
        rd(5'h14, r); check("R5 reloaded", r, 2);
        check("R5 irq", {31'b0, irq_a}, 1);
        pulse();
        rd(5'h14, r); check("R5 decrement", r, 1);

        // R3: reference source ignores prescaler
        wr(5'h04, 0);
        wr(5'h14, 5);
        idle(100);
        rd(5'h14, r); check("R3 no ref ticks", r, 5);

        // R9: freeze keeps count and status
        wr(5'h00, 0);
        pulse(); pulse();
        rd(5'h14, r); check("R9 frozen", r, 5);
        rd(5'h04, r); check("R9 status kept", r, 0);

        // R3/R6: one-shot from prescaled clock, divide by 8
        wr(5'h14, 0);
        wr(5'h00, 32'h0018_0001);
        idle(20);
        rd(5'h04, r); check("R3 prescaled expiry", r, 1);
        rd(5'h00, r); check("R6 prescaled stop", r, 32'h0018_0000);

        // R7: clear and expiry in the same cycle, expiry every clock
        wr(5'h10, 0); wr(5'h14, 0);
        wr(5'h00, 32'h0000_0003);
        wr(5'h04, 0);
        rd(5'h04, r); check("R7 set wins", r, 1);
        wr(5'h00, 0); wr(5'h04, 0);
        rd(5'h04, r); check("R7 cleared", r, 0);

        // R4: free-running all-ones count reads as inverted up-counter
        wr(5'h10, 32'hFFFF_FFFF); wr(5'h14, 32'hFFFF_FFFF);
        wr(5'h00, 32'h0000_0003);
        rd(5'h14, r);
        idle(7);
        rd(5'h14, r2);
        check("R4 inverted rising", {31'b0, (~r2 > ~r)}, 1);
        wr(5'h14, 32'h0000_1000);
        rd(5'h14, r); check("R4 load while running", r, 32'h0000_0FFF);

        // R10: both timers share the free-running prescaler (model compare)
        wr(5'h10, 3); wr(5'h14, 3); wr(5'h18, 1); wr(5'h1C, 1);
        wr(5'h00, (32'd5 << 19) | (32'd2 << 22) | 32'hF);
        for (int i = 0; i < 60; i++) begin
            rd(5'h14, r);
            rd(5'h1C, r);
            if (i % 7 == 0) wr(5'h04, 0);
            idle(8);
        end
        rd(5'h1C, r);
        check("R10 timer B bounded", {31'b0, (r <= 1)}, 1);
        wr(5'h00, 0);
        idle(4);
        finish_run();
    end
endmodule